// File: doc/BRIEF.md
# Pointer-Addressed Console Status Controller

This block is the host side of a single console serial channel, reduced to two byte-wide registers on a simple read/write bus: a control/status port and a data port. The control port is indirect. Every byte written to it is kept as a register pointer, and what a later control read returns depends on that pointer. One pointer value selects an interrupt vector view and returns the pointer to zero after the read. Any other pointer value selects a plain line status view. The same write also serves as a command channel: one fixed byte acknowledges the transmit interrupt.

The data port moves bytes. A write hands the byte to the transmit side as a one-cycle strobe and raises a transmit-pending bit at once. A read takes one byte from an external receive source, which presents a byte and a data-available flag and is told to advance by a pop pulse. The receive-pending bit rises whenever the source has data, with no enable, and drops once a read has drained the source. A single interrupt output is the OR of the two pending bits. A sticky error flag records host misuse: an acknowledge with nothing to acknowledge, or a data read from an empty source.

Top module: `ptr_console_ctrl`

## Requirements
- R1: After reset the pointer is 0, both pending bits, `irq`, `tx_stb` and `err_flag` are low, and a control read returns 0x04.
- R2: The control port sits at offset 0x80 and the data port at 0xC0. A read of any other offset returns 0x00, and a write to any other offset changes nothing.
- R3: Every control-port write stores the whole written byte as the pointer, whatever its value.
- R4: A control read while the pointer is 3 returns 0x10 when transmit is pending, otherwise 0x20 when receive is pending, otherwise 0x00. The pointer is then 0 from the next cycle.
- R5: A control read with any pointer other than 3 returns bit 2 set (transmitter ready) and bit 0 equal to the receive-pending bit, all other bits zero, and leaves the pointer unchanged.
- R6: A control write of 0x28 while transmit is pending clears the transmit-pending bit from the next cycle, so `irq` drops unless receive is pending. Any other control byte leaves the pending bits unchanged.
- R7: A data-port write drives `tx_stb` high for exactly the next cycle with the byte on `tx_data`, and sets the transmit-pending bit and `irq` from that same next cycle.
- R8: A data-port read while `rx_avail` is high returns `rx_byte` in the same cycle and pulses `rx_pop`. If `rx_avail` is low in the cycle after the pop, receive-pending clears on the following edge.
- R9: Whenever `rx_avail` is high, receive-pending and `irq` are set from the next cycle, with no enable involved.
- R10: A 0x28 control write with no transmit pending, or a data read while `rx_avail` is low, sets `err_flag`, which then stays high until reset. Such an empty read returns 0x00 and does not pulse `rx_pop`. Neither action changes the pending bits.
- R11: When `bus_wr` and `bus_rd` are high in the same cycle, the write is performed and the read is ignored: `bus_rdata` is 0x00, no pop and no pointer return occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register offset of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the cycle of `bus_rd` |
| rx_avail | input | 1 | Receive source holds at least one byte |
| rx_byte | input | 8 | Head byte of the receive source |
| rx_pop | output | 1 | Receive source advances at the clock edge |
| tx_data | output | 8 | Byte handed to the transmitter |
| tx_stb | output | 1 | One-cycle strobe qualifying `tx_data` |
| irq | output | 1 | Interrupt, high while either pending bit is set |
| err_flag | output | 1 | Sticky host misuse flag |

## Verification
The bench sweeps every pointer value and every non-acknowledge control byte, so a design that decoded only part of the pointer, matched the acknowledge byte loosely, or let the vector pointer leak into the plain status view returns the wrong status or clears the transmit interrupt too early. It checks the vector view priority with both interrupts pending, where a reversed priority reports receive instead of transmit, and that the pointer falls back to zero only after a vector read. It drains a two-byte source and looks at the interrupt one cycle after the last pop, which catches a design that clears receive-pending on the first pop or never clears it. Simultaneous read and write, empty reads and a spurious acknowledge expose designs that pop on a write, lose the sticky error, or disturb the pending bits.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // command byte that acknowledges the transmit interrupt
    localparam byte_t ACK_TX_CMD = 8'h28;
    // pointer value that selects the interrupt vector view
    localparam byte_t VEC_PTR    = 8'h03;

    // bit positions in the plain status view
    localparam int ST_RXP_BIT = 0;
    localparam int ST_RDY_BIT = 2;
    // bit positions in the vector view
    localparam int VEC_TX_BIT = 4;
    localparam int VEC_RX_BIT = 5;

    typedef struct packed {
        byte_t ptr;
        logic  tx_pend;
        logic  rx_pend;
        logic  pop_seen;
        logic  err;
        logic  tx_stb;
        byte_t tx_data;
    } ctl_state_t;

endpackage

// File: rtl/pcc_decode.sv
module pcc_decode #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h80,
    parameter logic [ADDR_W-1:0] DATA_OFS = 'hC0
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic              ctrl_wr,
    output logic              ctrl_rd,
    output logic              data_wr,
    output logic              data_rd
);
    logic hit_ctrl, hit_data, rd_ok;

    always_comb begin
        hit_ctrl = (bus_addr == CTRL_OFS);
        hit_data = (bus_addr == DATA_OFS);
        // a write in the same cycle wins over a read
        rd_ok    = bus_rd & ~bus_wr;
        ctrl_wr  = bus_wr & hit_ctrl;
        data_wr  = bus_wr & hit_data;
        ctrl_rd  = rd_ok  & hit_ctrl;
        data_rd  = rd_ok  & hit_data;
    end
endmodule

// File: rtl/pcc_rdmux.sv
module pcc_rdmux
    import pcc_pkg::*;
(
    input  logic  ctrl_rd,
    input  logic  data_rd,
    input  byte_t ptr_q,
    input  logic  tx_pend_q,
    input  logic  rx_pend_q,
    input  logic  rx_avail,
    input  byte_t rx_byte,
    output byte_t rdata
);
    always_comb begin
        rdata = '0;
        if (ctrl_rd) begin
            if (ptr_q == VEC_PTR) begin
                if (tx_pend_q)      rdata[VEC_TX_BIT] = 1'b1;
                else if (rx_pend_q) rdata[VEC_RX_BIT] = 1'b1;
            end else begin
                rdata[ST_RDY_BIT] = 1'b1;
                rdata[ST_RXP_BIT] = rx_pend_q;
            end
        end else if (data_rd && rx_avail) begin
            rdata = rx_byte;
        end
    end
endmodule

// File: rtl/pcc_next.sv
module pcc_next
    import pcc_pkg::*;
(
    input  ctl_state_t st_q,
    input  logic       ctrl_wr,
    input  logic       ctrl_rd,
    input  logic       data_wr,
    input  logic       data_rd,
    input  byte_t      wdata,
    input  logic       rx_avail,
    output ctl_state_t st_d
);
    always_comb begin
        st_d          = st_q;
        st_d.tx_stb   = 1'b0;
        st_d.pop_seen = 1'b0;

        // control port: pointer store and acknowledge command
        if (ctrl_wr) begin
            st_d.ptr = wdata;
            if (wdata == ACK_TX_CMD) begin
                if (st_q.tx_pend) st_d.tx_pend = 1'b0;
                else              st_d.err     = 1'b1;
            end
        end
        if (ctrl_rd && st_q.ptr == VEC_PTR) begin
            st_d.ptr = '0;
        end

        // data port: transmit and receive
        if (data_wr) begin
            st_d.tx_stb  = 1'b1;
            st_d.tx_data = wdata;
            st_d.tx_pend = 1'b1;
        end
        if (data_rd) begin
            if (rx_avail) st_d.pop_seen = 1'b1;
            else          st_d.err      = 1'b1;
        end

        // receive pending follows arrival, drops once a pop drained it
        if (rx_avail)           st_d.rx_pend = 1'b1;
        else if (st_q.pop_seen) st_d.rx_pend = 1'b0;
    end
endmodule

// File: rtl/ptr_console_ctrl.sv
module ptr_console_ctrl
    import pcc_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h80,
    parameter logic [ADDR_W-1:0] DATA_OFS = 'hC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rx_avail,
    input  logic [7:0]        rx_byte,
    output logic              rx_pop,
    output logic [7:0]        tx_data,
    output logic              tx_stb,
    output logic              irq,
    output logic              err_flag
);
    ctl_state_t st_q, st_d;
    logic ctrl_wr, ctrl_rd, data_wr, data_rd;
    byte_t ptr_q;
    logic  tx_pend_q, rx_pend_q;

    pcc_decode #(
        .ADDR_W  (ADDR_W),
        .CTRL_OFS(CTRL_OFS),
        .DATA_OFS(DATA_OFS)
    ) u_dec (
        .bus_addr(bus_addr),
        .bus_wr  (bus_wr),
        .bus_rd  (bus_rd),
        .ctrl_wr (ctrl_wr),
        .ctrl_rd (ctrl_rd),
        .data_wr (data_wr),
        .data_rd (data_rd)
    );

    pcc_rdmux u_rd (
        .ctrl_rd  (ctrl_rd),
        .data_rd  (data_rd),
        .ptr_q    (st_q.ptr),
        .tx_pend_q(st_q.tx_pend),
        .rx_pend_q(st_q.rx_pend),
        .rx_avail (rx_avail),
        .rx_byte  (rx_byte),
        .rdata    (bus_rdata)
    );

    pcc_next u_nxt (
        .st_q    (st_q),
        .ctrl_wr (ctrl_wr),
        .ctrl_rd (ctrl_rd),
        .data_wr (data_wr),
        .data_rd (data_rd),
        .wdata   (bus_wdata),
        .rx_avail(rx_avail),
        .st_d    (st_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{default: '0};
        else        st_q <= st_d;
    end

    always_comb begin
        ptr_q     = st_q.ptr;
        tx_pend_q = st_q.tx_pend;
        rx_pend_q = st_q.rx_pend;
        rx_pop    = data_rd & rx_avail;
        tx_data   = st_q.tx_data;
        tx_stb    = st_q.tx_stb;
        irq       = st_q.tx_pend | st_q.rx_pend;
        err_flag  = st_q.err;
    end
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h80,
    parameter logic [ADDR_W-1:0] DATA_OFS = 'hC0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              rx_avail,
    input logic              rx_pop,
    input logic              tx_stb,
    input logic              irq,
    input logic              err_flag,
    input logic [7:0]        ptr_q,
    input logic              tx_pend_q,
    input logic              rx_pend_q
);
    logic is_ctrl, is_data;
    assign is_ctrl = (bus_addr == CTRL_OFS);
    assign is_data = (bus_addr == DATA_OFS);

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !is_ctrl && !is_data) |-> (bus_rdata == 8'h00)); // R2
    AST_VEC_PTR_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && is_ctrl && ptr_q == 8'h03) |=> (ptr_q == 8'h00)); // R4
    AST_READY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && is_ctrl && ptr_q != 8'h03) |-> bus_rdata[2]); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_ctrl && bus_wdata == 8'h28 && tx_pend_q) |=> !tx_pend_q); // R6
    AST_TX_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_data) |=> (irq && tx_stb)); // R7
    AST_RX_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_avail |=> (rx_pend_q && irq)); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag); // R10
    AST_EMPTY_READ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && is_data && !rx_avail) |=> err_flag); // R10
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_rd) |-> (!rx_pop && bus_rdata == 8'h00)); // R11
endmodule

bind ptr_console_ctrl pcc_checker #(
    .ADDR_W  (ADDR_W),
    .CTRL_OFS(CTRL_OFS),
    .DATA_OFS(DATA_OFS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .rx_avail (rx_avail),
    .rx_pop   (rx_pop),
    .tx_stb   (tx_stb),
    .irq      (irq),
    .err_flag (err_flag),
    .ptr_q    (ptr_q),
    .tx_pend_q(tx_pend_q),
    .rx_pend_q(rx_pend_q)
);

// File: tb/sim_ptr_console_ctrl.sv
`timescale 1ns/1ps
module sim_ptr_console_ctrl;
    localparam logic [7:0] CTRL = 8'h80;
    localparam logic [7:0] DATA = 8'hC0;
    localparam logic [7:0] ACK  = 8'h28;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_avail;
    logic [7:0] rx_byte;
    logic       rx_pop;
    logic [7:0] tx_data;
    logic       tx_stb;
    logic       irq;
    logic       err_flag;

    int n_chk = 0;
    int n_fail = 0;
    int src_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    // receive source: head byte is 0xA0 plus the number of bytes held
    assign rx_avail = (src_cnt > 0);
    assign rx_byte  = 8'hA0 + 8'(src_cnt);
    always @(posedge clk) if (rx_pop) src_cnt <= src_cnt - 1;

    ptr_console_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_avail(rx_avail), .rx_byte(rx_byte), .rx_pop(rx_pop),
        .tx_data(tx_data), .tx_stb(tx_stb), .irq(irq), .err_flag(err_flag)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_op(input logic w, input logic r, input logic [7:0] a,
                          input logic [7:0] d, output logic [7:0] q, output logic pop);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        #1;
        q = bus_rdata;
        pop = rx_pop;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [7:0] q;
        logic p;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(irq, 0, "R1 irq"); chk(tx_stb, 0, "R1 tx_stb"); chk(err_flag, 0, "R1 err");
        rst_n = 1'b1;
        bus_op(0, 1, CTRL, 0, q, p);
        chk(q, 8'h04, "R1 status after reset");

        // R2 sweep reads and writes of unmapped offsets
        for (int a = 0; a < 256; a++) begin
            if (a == 'h80 || a == 'hC0) continue;
            bus_op(0, 1, 8'(a), 0, q, p);
            chk(q, 0, "R2 unmapped read");
            bus_op(1, 0, 8'(a), 8'h55, q, p);
            chk({tx_stb, irq, err_flag}, 0, "R2 unmapped write");
        end
        bus_op(0, 1, CTRL, 0, q, p);
        chk(q, 8'h04, "R2 pointer untouched by unmapped writes");

        // R3/R5 every pointer except vector and acknowledge gives plain status
        for (int v = 0; v < 256; v++) begin
            if (v == 3 || v == 'h28) continue;
            bus_op(1, 0, CTRL, 8'(v), q, p);
            bus_op(0, 1, CTRL, 0, q, p);
            chk(q, 8'h04 | 8'(0), "R5 plain status");
            bus_op(0, 1, CTRL, 0, q, p);
            chk(q, 8'h04, "R3 pointer kept after read");
        end
        // R4 vector view with nothing pending
        bus_op(1, 0, CTRL, 8'h03, q, p);
        bus_op(0, 1, CTRL, 0, q, p);
        chk(q, 8'h00, "R4 vector idle");
        bus_op(0, 1, CTRL, 0, q, p);
        chk(q, 8'h04, "R4 pointer returned to 0");

        // R7 data write
        bus_op(1, 0, DATA, 8'h5A, q, p);
        chk(tx_stb, 1, "R7 strobe"); chk(tx_data, 8'h5A, "R7 byte"); chk(irq, 1, "R7 irq");
        idle();
        chk(tx_stb, 0, "R7 strobe one cycle");

        // R6 only the acknowledge byte clears transmit pending
        for (int v = 0; v < 256; v++) begin
            if (v == 'h28) continue;
            bus_op(1, 0, CTRL, 8'(v), q, p);
            chk(irq, 1, "R6 non-ack byte keeps irq");
        end
        bus_op(1, 0, CTRL, 8'h03, q, p);
        bus_op(0, 1, CTRL, 0, q, p);
        chk(q, 8'h10, "R4 vector tx");
        bus_op(1, 0, CTRL, ACK, q, p);
        chk(irq, 0, "R6 ack clears irq");
        chk(err_flag, 0, "R6 valid ack no error");
        bus_op(0, 1, CTRL, 0, q, p);
        chk(q, 8'h04, "R3 ack byte is pointer");

        // R9 arrival without enable
        src_cnt = 2;
        idle();
        chk(irq, 1, "R9 arrival irq");
        bus_op(1, 0, CTRL, 8'h00, q, p);
        bus_op(0, 1, CTRL, 0, q, p);
        chk(q, 8'h05, "R5 rx bit");
        bus_op(1, 0, CTRL, 8'h03, q, p);
        bus_op(0, 1, CTRL, 0, q, p);
        chk(q, 8'h20, "R4 vector rx");

        // R4 priority and R6 ack with rx still pending
        bus_op(1, 0, DATA, 8'hC3, q, p);
        bus_op(1, 0, CTRL, 8'h03, q, p);
        bus_op(0, 1, CTRL, 0, q, p);
        chk(q, 8'h10, "R4 tx over rx");
        bus_op(1, 0, CTRL, ACK, q, p);
        chk(irq, 1, "R6 irq held by rx");

        // R8 drain two bytes
        bus_op(0, 1, DATA, 0, q, p);
        chk(q, 8'hA2, "R8 first byte"); chk(p, 1, "R8 pop");
        bus_op(0, 1, DATA, 0, q, p);
        chk(q, 8'hA1, "R8 second byte");
        chk(irq, 1, "R8 pending until settled");
        idle();
        chk(irq, 0, "R8 drained clears");
        bus_op(1, 0, CTRL, 8'h00, q, p);
        bus_op(0, 1, CTRL, 0, q, p);
        chk(q, 8'h04, "R8 rx bit cleared");

        // R11 write beats read
        src_cnt = 1;
        bus_op(1, 1, DATA, 8'h33, q, p);
        chk(p, 0, "R11 no pop"); chk(q, 0, "R11 read ignored");
        chk(tx_stb, 1, "R11 write done"); chk(tx_data, 8'h33, "R11 byte");
        bus_op(0, 1, DATA, 0, q, p);
        chk(q, 8'hA1, "R11 byte still held");
        bus_op(1, 0, CTRL, ACK, q, p);
        idle();
        chk(irq, 0, "R11 all clear");

        // R10 misuse
        chk(err_flag, 0, "R10 no error yet");
        bus_op(0, 1, DATA, 0, q, p);
        chk(q, 0, "R10 empty read data"); chk(p, 0, "R10 empty no pop");
        chk(err_flag, 1, "R10 empty read error");
        chk(irq, 0, "R10 pending untouched");
        bus_op(1, 0, CTRL, ACK, q, p);
        chk(irq, 0, "R10 spurious ack no irq");
        repeat (5) idle();
        chk(err_flag, 1, "R10 sticky");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule